// File: doc/BRIEF.md
# PCI Configuration-Cycle Initiator with Abort Reporting

This block sits on the AHB slave side of an AHB-to-PCI bridge. An AHB access inside the configuration window is turned into one PCI configuration transaction. The device, function, dword register and byte enables of that transaction are taken from the AHB address and size. The PCI side is a plain request/acknowledge handshake. A two-bit abort code comes back with the acknowledge.

When a read on the PCI side ends in a target-abort or a master-abort, the block records the cause in sticky status bits of a small control register. It then either returns a two-cycle AHB ERROR response or completes with OKAY and all-ones data. The choice depends on an error-enable bit. A separate interrupt-enable bit decides whether the recorded cause drives the interrupt output. The control register has its own AHB select and takes no wait states.

Top module: `pci_cfg_initiator`

## Requirements
- R1: After reset, hready_o is 1, hresp_o is 0, pci_req_o is 0 and irq_o is 0, and the control register reads 0.
- R2: A configuration-window access drives pci_dev_o from haddr_i[15:11], pci_func_o from haddr_i[10:8] and pci_reg_o from haddr_i[7:2]; haddr_i[31:16] has no effect. A read with abort code 0 returns pci_rdata_i with an OKAY response.
- R3: pci_be_o (active high) is computed from hsize_i and haddr_i[1:0]. For a byte (hsize 0) it is 1 shifted left by haddr_i[1:0]. For a halfword (hsize 1) it is 4'b0011 shifted left by 2*haddr_i[1]. For a word (hsize 2) it is 4'b1111.
- R4: A read whose acknowledge carries a non-zero pci_abort_i while the error-enable bit is 1 ends with a two-cycle ERROR. In the first cycle hresp_o is 1 and hready_o is 0; in the next cycle both are 1.
- R5: The same aborted read with the error-enable bit at 0 completes with OKAY and hrdata_o = 32'hFFFF_FFFF.
- R6: pci_abort_i bit 0 is target-abort and bit 1 is master-abort. An aborted read sets control bit 8 for target-abort and bit 9 for master-abort, whatever the enable bits are. These bits stay set until a control write puts a 1 in that bit position.
- R7: irq_o is 1 exactly when the interrupt-enable bit is 1 and at least one of control bits 9:8 is set.
- R8: A configuration write drives pci_write_o = 1 and pci_wdata_o = hwdata_i. An abort on a write is ignored: the response is OKAY and the status bits do not change.
- R9: Control bit 0 is error-enable and bit 1 is interrupt-enable. Both are read/write. All bits other than 0, 1, 8 and 9 read 0.
- R10: pci_req_o stays high, with its address fields stable, until pci_ack_i. hready_o is low from the cycle after the address phase up to the acknowledge, so a response delay of N cycles gives N wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_cfg_i | input | 1 | Select for the configuration window |
| hsel_reg_i | input | 1 | Select for the control register |
| htrans_i | input | 2 | AHB transfer type |
| hwrite_i | input | 1 | AHB write |
| hsize_i | input | 3 | AHB transfer size |
| haddr_i | input | 32 | AHB address |
| hwdata_i | input | 32 | AHB write data |
| hready_i | input | 1 | AHB bus ready |
| hready_o | output | 1 | Slave ready |
| hresp_o | output | 1 | Slave response, 1 = ERROR |
| hrdata_o | output | 32 | Read data |
| irq_o | output | 1 | Abort interrupt |
| pci_req_o | output | 1 | Configuration transaction request |
| pci_write_o | output | 1 | Transaction is a write |
| pci_dev_o | output | 5 | Target device number |
| pci_func_o | output | 3 | Target function number |
| pci_reg_o | output | 6 | Dword register index |
| pci_be_o | output | 4 | Byte enables, active high |
| pci_wdata_o | output | 32 | Write data |
| pci_ack_i | input | 1 | Transaction done |
| pci_abort_i | input | 2 | Termination code, bit 0 target-abort, bit 1 master-abort |
| pci_rdata_i | input | 32 | Read data from PCI |

## Verification
The bench uses the default parameters; the address fields are fixed at 5, 3 and 6 bits. It sweeps every device and function number against three register indices, with the unused upper address bits scrambled. It covers every legal size and offset pair for the byte enables. It runs the whole matrix of the two enable bits against the three non-zero abort codes. The response delay is varied from one to four cycles, so the wait-state count and the held request are checked at several lengths.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int REG_W  = 6;
  localparam int BE_W   = 4;
  localparam int WIN_W  = 16;

  localparam int CTRL_ER_BIT = 0;
  localparam int CTRL_EI_BIT = 1;
  localparam int STS_LSB     = 8;
  localparam int STS_W       = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_RESP, ST_ERR1, ST_ERR2
  } bridge_st_e;

  typedef struct packed {
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [REG_W-1:0]  regno;
    logic [BE_W-1:0]   be;
  } cfg_addr_t;
endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
  import pci_cfg_pkg::*;
(
  input  logic [WIN_W-1:0] addr_i,
  input  logic [2:0]       size_i,
  output cfg_addr_t        cfg_o
);
  localparam int REG_LSB  = 2;
  localparam int FUNC_LSB = REG_LSB + REG_W;
  localparam int DEV_LSB  = FUNC_LSB + FUNC_W;

  always_comb begin
    cfg_o.dev   = addr_i[DEV_LSB +: DEV_W];
    cfg_o.func  = addr_i[FUNC_LSB +: FUNC_W];
    cfg_o.regno = addr_i[REG_LSB +: REG_W];
    unique case (size_i)
      3'd0:    cfg_o.be = BE_W'(1) << addr_i[1:0];
      3'd1:    cfg_o.be = addr_i[1] ? 4'b1100 : 4'b0011;
      default: cfg_o.be = '1;
    endcase
  end
endmodule

// File: rtl/pci_cfg_ctrl.sv
module pci_cfg_ctrl
  import pci_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wdata_i,
  input  logic [STS_W-1:0] set_i,
  output logic             er_o,
  output logic             ei_o,
  output logic [STS_W-1:0] sts_o,
  output logic [31:0]      rdata_o,
  output logic             irq_o
);
  logic er_q, ei_q;
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      er_q <= 1'b0;
      ei_q <= 1'b0;
    end else if (wr_en_i) begin
      er_q <= wdata_i[CTRL_ER_BIT];
      ei_q <= wdata_i[CTRL_EI_BIT];
    end
  end

  for (genvar g = 0; g < STS_W; g++) begin : g_sts
    logic bit_q;
    // a new abort wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                bit_q <= 1'b0;
      else if (set_i[g])                          bit_q <= 1'b1;
      else if (wr_en_i && wdata_i[STS_LSB + g])   bit_q <= 1'b0;
    end
    assign sts_o[g] = bit_q;

    assert_sts_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> bit_q);
    assert_sts_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bit_q && !(wr_en_i && wdata_i[STS_LSB + g])) |=> bit_q);
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[CTRL_ER_BIT] = er_q;
    rdata_o[CTRL_EI_BIT] = ei_q;
    rdata_o[STS_LSB +: STS_W] = sts_o;
  end

  assign er_o  = er_q;
  assign ei_o  = ei_q;
  assign irq_o = ei_q & (|sts_o);
endmodule

// File: rtl/pci_cfg_initiator.sv
module pci_cfg_initiator
  import pci_cfg_pkg::*;
#(
  parameter logic [31:0] ABORT_FILL = 32'hFFFF_FFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hsel_cfg_i,
  input  logic        hsel_reg_i,
  input  logic [1:0]  htrans_i,
  input  logic        hwrite_i,
  input  logic [2:0]  hsize_i,
  input  logic [31:0] haddr_i,
  input  logic [31:0] hwdata_i,
  input  logic        hready_i,
  output logic        hready_o,
  output logic        hresp_o,
  output logic [31:0] hrdata_o,
  output logic        irq_o,
  output logic        pci_req_o,
  output logic        pci_write_o,
  output logic [4:0]  pci_dev_o,
  output logic [2:0]  pci_func_o,
  output logic [5:0]  pci_reg_o,
  output logic [3:0]  pci_be_o,
  output logic [31:0] pci_wdata_o,
  input  logic        pci_ack_i,
  input  logic [1:0]  pci_abort_i,
  input  logic [31:0] pci_rdata_i
);
  bridge_st_e st_q, st_d;
  logic [WIN_W-1:0] addr_q;
  logic [2:0]       size_q;
  logic             wr_q, dp_reg_q, dp_wr_q;
  logic [31:0]      rdata_q, ctrl_rdata;
  logic             er, ei, ready_st, acc, acc_cfg, acc_reg, ack_now, aborted;
  logic [STS_W-1:0] sts, sts_set;
  cfg_addr_t        cfg;
  logic             unused_in;

  assign unused_in = ^{htrans_i[0], haddr_i[31:WIN_W], sts, ei};

  assign acc     = htrans_i[1] && hready_i;
  assign acc_cfg = acc && hsel_cfg_i;
  assign acc_reg = acc && hsel_reg_i && !hsel_cfg_i;
  assign ready_st = (st_q == ST_IDLE) || (st_q == ST_RESP) || (st_q == ST_ERR2);
  assign ack_now  = (st_q == ST_WAIT) && pci_ack_i;
  assign aborted  = |pci_abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      size_q   <= '0;
      wr_q     <= 1'b0;
      dp_reg_q <= 1'b0;
      dp_wr_q  <= 1'b0;
    end else if (hready_i) begin
      dp_reg_q <= acc_reg;
      dp_wr_q  <= hwrite_i;
      if (acc_cfg) begin
        addr_q <= haddr_i[WIN_W-1:0];
        size_q <= hsize_i;
        wr_q   <= hwrite_i;
      end
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT: if (pci_ack_i)
                 st_d = (!wr_q && aborted && er) ? ST_ERR1 : ST_RESP;
      ST_ERR1: st_d = ST_ERR2;
      default: st_d = acc_cfg ? ST_WAIT : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (ack_now) rdata_q <= aborted ? ABORT_FILL : pci_rdata_i;
    end
  end

  assign sts_set = (ack_now && !wr_q) ? pci_abort_i : '0;

  pci_cfg_decode u_decode (
    .addr_i (addr_q),
    .size_i (size_q),
    .cfg_o  (cfg)
  );

  pci_cfg_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (dp_reg_q && dp_wr_q && ready_st),
    .wdata_i (hwdata_i),
    .set_i   (sts_set),
    .er_o    (er),
    .ei_o    (ei),
    .sts_o   (sts),
    .rdata_o (ctrl_rdata),
    .irq_o   (irq_o)
  );

  assign hready_o    = (st_q != ST_WAIT) && (st_q != ST_ERR1);
  assign hresp_o     = (st_q == ST_ERR1) || (st_q == ST_ERR2);
  assign hrdata_o    = dp_reg_q ? ctrl_rdata : ((st_q == ST_RESP) ? rdata_q : '0);
  assign pci_req_o   = (st_q == ST_WAIT);
  assign pci_write_o = wr_q;
  assign pci_dev_o   = cfg.dev;
  assign pci_func_o  = cfg.func;
  assign pci_reg_o   = cfg.regno;
  assign pci_be_o    = cfg.be;
  // master holds hwdata_i for the whole stalled data phase
  assign pci_wdata_o = hwdata_i;

  assert_err_two_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && !hready_o) |=> (hresp_o && hready_o));
  assert_err_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && !hready_o) |-> er);
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_req_o && !pci_ack_i) |=> (pci_req_o && $stable(pci_dev_o) &&
      $stable(pci_func_o) && $stable(pci_reg_o) && $stable(pci_be_o)));
  assert_stall_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_o |-> (pci_req_o || hresp_o));
endmodule

// File: tb/pci_cfg_initiator_bench.sv
module pci_cfg_initiator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel_cfg = 0, hsel_reg = 0, hwrite = 0;
  logic [1:0]  htrans = 0;
  logic [2:0]  hsize = 0;
  logic [31:0] haddr = 0, hwdata = 0;
  logic        hready, hresp, irq, req, pwr, ack = 0;
  logic [31:0] hrdata, pwdata, prdata;
  logic [4:0]  pdev;
  logic [2:0]  pfunc;
  logic [5:0]  preg;
  logic [3:0]  pbe;
  logic [1:0]  abort_code = 0;

  int checks = 0, fails = 0, rsp_delay = 1, cnt = 0;
  bit done = 0;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_func;
  logic [5:0]  cap_reg;
  logic [3:0]  cap_be;
  logic        cap_wr;
  logic [31:0] cap_wdata;

  always #10 clk = ~clk;

  assign prdata = {13'h0, pdev, pfunc, preg, pbe, 1'b0};

  pci_cfg_initiator u_pci_cfg_initiator (
    .clk_i(clk), .rst_ni(rst_n), .hsel_cfg_i(hsel_cfg), .hsel_reg_i(hsel_reg),
    .htrans_i(htrans), .hwrite_i(hwrite), .hsize_i(hsize), .haddr_i(haddr),
    .hwdata_i(hwdata), .hready_i(hready), .hready_o(hready), .hresp_o(hresp),
    .hrdata_o(hrdata), .irq_o(irq), .pci_req_o(req), .pci_write_o(pwr),
    .pci_dev_o(pdev), .pci_func_o(pfunc), .pci_reg_o(preg), .pci_be_o(pbe),
    .pci_wdata_o(pwdata), .pci_ack_i(ack), .pci_abort_i(abort_code),
    .pci_rdata_i(prdata));

  // PCI responder: acknowledges after rsp_delay cycles of request
  always @(negedge clk) begin
    if (!rst_n) begin ack = 0; cnt = 0; end
    else if (ack) ack = 0;
    else if (req) begin
      cnt = cnt + 1;
      if (cnt >= rsp_delay) begin
        ack = 1; cnt = 0;
        cap_dev = pdev; cap_func = pfunc; cap_reg = preg; cap_be = pbe;
        cap_wr = pwr; cap_wdata = pwdata;
      end
    end
  end

  task automatic check(input bit ok, input string req_tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic xfer(input bit is_reg, input bit wr, input logic [31:0] addr,
                      input logic [2:0] size, input logic [31:0] wdata,
                      output logic [31:0] rdata, output logic resp,
                      output int nwait, output bit err_lo);
    hsel_cfg = !is_reg; hsel_reg = is_reg; htrans = 2'b10;
    hwrite = wr; haddr = addr; hsize = size;
    @(posedge clk); @(negedge clk);
    htrans = 2'b00; hsel_cfg = 0; hsel_reg = 0; hwdata = wdata;
    nwait = 0; err_lo = 0;
    while (!hready) begin
      nwait++;
      if (hresp) err_lo = 1;
      @(negedge clk);
    end
    rdata = hrdata; resp = hresp;
  endtask

  task automatic ctrl_wr(input logic [31:0] v);
    logic [31:0] d; logic r; int n; bit e;
    xfer(1, 1, 32'h0, 3'd2, v, d, r, n, e);
  endtask

  task automatic ctrl_rd(output logic [31:0] v);
    logic r; int n; bit e;
    xfer(1, 0, 32'h0, 3'd2, 32'h0, v, r, n, e);
  endtask

  initial begin
    logic [31:0] d, a, exp;
    logic r;
    int n;
    bit e;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(hready === 1 && hresp === 0 && req === 0 && irq === 0, "R1",
          {hready, hresp, req, irq}, 32'h8);
    rst_n = 1;
    @(negedge clk);
    ctrl_rd(d);
    check(d === 0, "R1", d, 0);

    // R2/R10: device x function x register sweep, upper bits scrambled
    foreach (a[i]) a[i] = 0;
    for (int dv = 0; dv < 32; dv++)
      for (int fn = 0; fn < 8; fn++)
        for (int ri = 0; ri < 3; ri++) begin
          logic [5:0] rg;
          rg = (ri == 0) ? 6'd0 : (ri == 1) ? 6'd21 : 6'd63;
          rsp_delay = 1 + (dv % 4);
          a = {16'(dv * 7919 + fn * 131 + ri), 5'(dv), 3'(fn), rg, 2'b00};
          xfer(0, 0, a, 3'd2, 0, d, r, n, e);
          exp = {13'h0, 5'(dv), 3'(fn), rg, 4'hF, 1'b0};
          check(d === exp && r === 0, "R2", d, exp);
          check(n == rsp_delay, "R10", n, rsp_delay);
        end

    // R3 byte enables
    rsp_delay = 2;
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 4; off++) begin
        logic [3:0] be_exp;
        if (sz == 1 && off[0]) continue;
        if (sz == 2 && off != 0) continue;
        be_exp = (sz == 0) ? 4'(1 << off) : (sz == 1) ? 4'(3 << (2 * (off / 2))) : 4'hF;
        xfer(0, 0, 32'h0000_5A00 | off, 3'(sz), 0, d, r, n, e);
        check(cap_be === be_exp, "R3", cap_be, be_exp);
      end

    // R8 write forwarding
    xfer(0, 1, 32'h0000_8B14, 3'd2, 32'hCAFE_0123, d, r, n, e);
    check(cap_wr === 1 && cap_wdata === 32'hCAFE_0123 && r === 0, "R8",
          cap_wdata, 32'hCAFE_0123);

    // R4/R5/R6/R7/R9 abort matrix
    for (int er = 0; er < 2; er++)
      for (int ei = 0; ei < 2; ei++)
        for (int code = 1; code < 4; code++) begin
          ctrl_wr(32'h300 | (ei << 1) | er);
          abort_code = 2'(code);
          xfer(0, 0, 32'h0000_1104, 3'd2, 0, d, r, n, e);
          abort_code = 0;
          if (er) begin
            check(r === 1 && e && n == rsp_delay + 1, "R4", {r, 31'(n)}, {1'b1, 31'(rsp_delay + 1)});
          end else begin
            check(r === 0 && d === 32'hFFFF_FFFF, "R5", d, 32'hFFFF_FFFF);
          end
          check(irq === 1'(ei), "R7", irq, ei);
          ctrl_rd(d);
          exp = (code << 8) | (ei << 1) | er;
          check(d === exp, "R6", d, exp);
        end

    // R6 write-one-to-clear, one bit at a time; R7 irq follows
    ctrl_wr(32'h302);
    abort_code = 2'd3;
    xfer(0, 0, 32'h0000_2208, 3'd2, 0, d, r, n, e);
    abort_code = 0;
    ctrl_wr(32'h102);
    ctrl_rd(d);
    check(d === 32'h202, "R6", d, 32'h202);
    check(irq === 1, "R7", irq, 1);
    ctrl_wr(32'h202);
    ctrl_rd(d);
    check(d === 32'h002, "R6", d, 32'h002);
    check(irq === 0, "R7", irq, 0);

    // R8 write abort ignored
    ctrl_wr(32'h303);
    abort_code = 2'd3;
    xfer(0, 1, 32'h0000_3310, 3'd2, 32'h1, d, r, n, e);
    abort_code = 0;
    check(r === 0 && !e, "R8", r, 0);
    ctrl_rd(d);
    check(d === 32'h003 && irq === 0, "R8", d, 32'h003);

    // R9 unimplemented bits read zero
    ctrl_wr(32'hFFFF_FCFC);
    ctrl_rd(d);
    check(d === 0, "R9", d, 0);
    ctrl_wr(32'hFFFF_FFFF);
    ctrl_rd(d);
    check(d === 32'h3, "R9", d, 32'h3);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule